// File: doc/BRIEF.md
# Serial Programming Register with Control-Bit Routing

This block receives configuration words for a frequency synthesizer over a three-wire serial link: a serial clock, a serial data line and a load strobe. All three inputs are sampled into the system clock domain. Each rising edge of the serial clock captures one data bit into a 19-bit shift register while the load strobe is low. A rising edge of the load strobe then copies the shifted word into one of two latch sets. The last bit shifted in is the routing bit, and it decides which set receives the word.

The reference set holds the 14-bit reference divide value and four single-bit mode controls: prescaler modulus select, phase-detector polarity, monitor output select and charge-pump current select. The divider set holds the 7-bit swallow count and the 11-bit main count. The rest of the synthesizer reads these latched values directly from the output ports.

A small state machine drives the load strobe handling. It has three states. ACCEPT takes serial bits. COMMIT lasts one cycle and writes the selected latch. WAIT_LOW ignores all serial activity until the strobe falls. The transitions are:
- ACCEPT to COMMIT on a strobe rising edge.
- COMMIT to WAIT_LOW if the strobe is still high, or COMMIT to ACCEPT if it is already low.
- WAIT_LOW to ACCEPT when the strobe is low.

Top module: `serial_prog_reg`

## Requirements
- R1: While the strobe is low, each rising edge of the serial clock shifts one bit in. Bits are sent MSB first, and the 19th bit sent is the routing bit.
- R2: Routing bit 1 loads the reference set. The fields, from first bit sent to last, are: current select (`cp_high`), monitor select (`mon_select`), detector polarity (`pd_polarity`), modulus select (`mod_small`), reference value bit 13 down to bit 0, then the routing bit.
- R3: Routing bit 0 loads the divider set. The fields, from first bit sent to last, are: main count bit 10 down to bit 0, swallow count bit 6 down to bit 0, then the routing bit.
- R4: A transfer changes only the set selected by the routing bit. The other set keeps its values.
- R5: Latches change only on a strobe rising edge. Keeping the strobe high causes no second transfer. Serial clock edges while the strobe is high shift nothing in.
- R6: A reference word whose value field is below 3 is rejected as a whole: no field of the reference set changes. A value of exactly 3 is accepted.
- R7: After reset, the outputs are: reference value 3, all four mode bits 0, main count 3, swallow count 0.
- R8: Reset clears the shift register. A transfer with no bits sent after reset therefore loads the divider set with main count 0 and swallow count 0.
- R9: A serial clock rising edge seen in the same system cycle as the strobe rising edge is discarded. The transfer uses the 19 bits that were already shifted in.
- R10: When more than 19 bits are sent, only the last 19 bits take part in the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; a bit is captured on its rising edge |
| ser_data | input | 1 | Serial data bit |
| ser_load | input | 1 | Load strobe; a rising edge transfers the word |
| ref_div | output | 14 | Latched reference divide value |
| mod_small | output | 1 | Prescaler modulus select |
| pd_polarity | output | 1 | Phase-detector polarity |
| mon_select | output | 1 | Monitor output select |
| cp_high | output | 1 | Charge-pump current select |
| main_n | output | 11 | Latched main count |
| swallow_a | output | 7 | Latched swallow count |

## Verification
A serial clock edge and a strobe rising edge can fall into the same system cycle. In that cycle, shifting and transfer would both act on the shift register. The bench provokes this case by raising the serial clock, with the data line at 1, at the same instant as the strobe, after a complete divider word has been sent. If the extra bit were shifted in, the routing bit would become 1 and the transfer would target the reference set. The bench therefore judges the result by checking that the divider set holds exactly the original word and that the reference set is unchanged.

// File: rtl/spr_pkg.sv
package spr_pkg;
    typedef enum logic [1:0] {
        ST_ACCEPT   = 2'd0,
        ST_COMMIT   = 2'd1,
        ST_WAIT_LOW = 2'd2
    } ld_state_t;
endpackage

// File: rtl/spr_sync.sv
module spr_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/spr_ctrl.sv
module spr_ctrl
    import spr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic le_lvl,
    input  logic le_rise,
    output logic shift_allow,
    output logic commit
);
    ld_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ACCEPT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACCEPT:   if (le_rise) state_d = ST_COMMIT;
            ST_COMMIT:   state_d = le_lvl ? ST_WAIT_LOW : ST_ACCEPT;
            ST_WAIT_LOW: if (!le_lvl) state_d = ST_ACCEPT;
            default:     state_d = ST_ACCEPT;
        endcase
    end

    always_comb begin
        shift_allow = 1'b0;
        commit      = 1'b0;
        unique case (state_q)
            ST_ACCEPT:   shift_allow = !le_lvl;
            ST_COMMIT:   commit = 1'b1;
            ST_WAIT_LOW: ;
            default:     ;
        endcase
    end

    // R5: a transfer is a single cycle, never repeated back to back
    p_commit_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_COMMIT |=> state_q != ST_COMMIT);
endmodule

// File: rtl/spr_shift.sv
module spr_shift #(
    parameter int W = 19
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        word <= '0;
        else if (shift_en) word <= {word[W-2:0], din};
    end
endmodule

// File: rtl/serial_prog_reg.sv
module serial_prog_reg #(
    parameter int REF_W     = 14,
    parameter int A_W       = 7,
    parameter int N_W       = 11,
    parameter int SYNC_STG  = 2,
    parameter int REF_MIN   = 3,
    parameter int REF_RESET = 3,
    parameter int N_RESET   = 3
) (
    input  logic             sys_clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_data,
    input  logic             ser_load,
    output logic [REF_W-1:0] ref_div,
    output logic             mod_small,
    output logic             pd_polarity,
    output logic             mon_select,
    output logic             cp_high,
    output logic [N_W-1:0]   main_n,
    output logic [A_W-1:0]   swallow_a
);
    localparam int WORD_W = REF_W + 5;
    localparam int DIV_W  = N_W + A_W + 1;

    logic [2:0]        sync_q;
    logic              sclk_s, sdat_s, le_s;
    logic              sclk_prev, le_prev;
    logic              sclk_rise, le_rise;
    logic              shift_allow, commit;
    logic [WORD_W-1:0] word;
    logic              ref_ok;

    spr_sync #(.W(3), .STAGES(SYNC_STG)) u_sync (
        .clk(sys_clk), .rst_n(rst_n),
        .d({ser_clk, ser_data, ser_load}), .q(sync_q)
    );
    assign {sclk_s, sdat_s, le_s} = sync_q;

    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            le_prev   <= 1'b0;
        end else begin
            sclk_prev <= sclk_s;
            le_prev   <= le_s;
        end
    end
    assign sclk_rise = sclk_s & ~sclk_prev;
    assign le_rise   = le_s & ~le_prev;

    spr_ctrl u_ctrl (
        .clk(sys_clk), .rst_n(rst_n), .le_lvl(le_s), .le_rise(le_rise),
        .shift_allow(shift_allow), .commit(commit)
    );

    spr_shift #(.W(WORD_W)) u_shift (
        .clk(sys_clk), .rst_n(rst_n), .shift_en(shift_allow & sclk_rise),
        .din(sdat_s), .word(word)
    );

    assign ref_ok = (word[REF_W:1] >= REF_W'(REF_MIN));

    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_div     <= REF_W'(REF_RESET);
            mod_small   <= 1'b0;
            pd_polarity <= 1'b0;
            mon_select  <= 1'b0;
            cp_high     <= 1'b0;
            main_n      <= N_W'(N_RESET);
            swallow_a   <= '0;
        end else if (commit) begin
            if (word[0]) begin
                if (ref_ok) begin
                    ref_div     <= word[REF_W:1];
                    mod_small   <= word[REF_W+1];
                    pd_polarity <= word[REF_W+2];
                    mon_select  <= word[REF_W+3];
                    cp_high     <= word[REF_W+4];
                end
            end else begin
                swallow_a <= word[A_W:1];
                main_n    <= word[DIV_W-1:A_W+1];
            end
        end
    end

    // R6: the reference value never leaves its legal range
    p_ref_legal_r6: assert property (@(posedge sys_clk) disable iff (!rst_n)
        ref_div >= REF_W'(REF_MIN));
    // R4: a single transfer never touches both sets
    p_one_target_r4: assert property (@(posedge sys_clk) disable iff (!rst_n)
        !(!$stable({ref_div, mod_small, pd_polarity, mon_select, cp_high}) &&
          !$stable({main_n, swallow_a})));
    // R5: with the strobe high the shift register is frozen
    p_le_freezes_r5: assert property (@(posedge sys_clk) disable iff (!rst_n)
        le_s |=> $stable(word));
    // R5: latches move only after a strobe rising edge was seen
    p_quiet_latch_r5: assert property (@(posedge sys_clk) disable iff (!rst_n)
        !le_s |=> $stable({ref_div, mod_small, pd_polarity, mon_select,
                          cp_high, main_n, swallow_a}));
endmodule

// File: tb/sim_serial_prog_reg.sv
module sim_serial_prog_reg;
    localparam int CLK_PERIOD = 10;

    logic        sys_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
    logic [13:0] ref_div;
    logic        mod_small, pd_polarity, mon_select, cp_high;
    logic [10:0] main_n;
    logic [6:0]  swallow_a;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) sys_clk = ~sys_clk;

    serial_prog_reg u0 (
        .sys_clk(sys_clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_load(ser_load), .ref_div(ref_div), .mod_small(mod_small),
        .pd_polarity(pd_polarity), .mon_select(mon_select), .cp_high(cp_high),
        .main_n(main_n), .swallow_a(swallow_a)
    );

    task automatic wait_cyc(int n);
        repeat (n) @(negedge sys_clk);
    endtask

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic send_bit(logic b);
        ser_data = b;
        wait_cyc(4);
        ser_clk = 1'b1;
        wait_cyc(4);
        ser_clk = 1'b0;
        wait_cyc(4);
    endtask

    task automatic send_word(logic [18:0] w);
        for (int i = 18; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic pulse_load();
        ser_load = 1'b1;
        wait_cyc(8);
        ser_load = 1'b0;
        wait_cyc(8);
    endtask

    function automatic logic [18:0] ref_word(logic cs, logic lds, logic fc,
                                             logic sw, logic [13:0] r);
        return {cs, lds, fc, sw, r, 1'b1};
    endfunction

    function automatic logic [18:0] div_word(logic [10:0] n, logic [6:0] a);
        return {n, a, 1'b0};
    endfunction

    task automatic check_ref(string req, int r, int cs, int lds, int fc, int sw);
        check(req, "ref_div", int'(ref_div), r);
        check(req, "cp_high", int'(cp_high), cs);
        check(req, "mon_select", int'(mon_select), lds);
        check(req, "pd_polarity", int'(pd_polarity), fc);
        check(req, "mod_small", int'(mod_small), sw);
    endtask

    task automatic check_div(string req, int n, int a);
        check(req, "main_n", int'(main_n), n);
        check(req, "swallow_a", int'(swallow_a), a);
    endtask

    task automatic t_reset_r7();
        check_ref("R7", 3, 0, 0, 0, 0);
        check_div("R7", 3, 0);
    endtask

    task automatic t_cleared_r8();
        pulse_load();
        check_div("R8", 0, 0);
        check_ref("R8", 3, 0, 0, 0, 0);
    endtask

    task automatic t_ref_load_r2();
        send_word(ref_word(1'b1, 1'b0, 1'b1, 1'b0, 14'h2A5B));
        pulse_load();
        check_ref("R2", 14'h2A5B, 1, 0, 1, 0);
        check_div("R4", 0, 0);
    endtask

    task automatic t_div_load_r3();
        send_word(div_word(11'h5A3, 7'h55));
        pulse_load();
        check_div("R3", 11'h5A3, 7'h55);
        check_ref("R4", 14'h2A5B, 1, 0, 1, 0);
    endtask

    task automatic t_ref_limit_r6();
        send_word(ref_word(1'b0, 1'b1, 1'b0, 1'b1, 14'd2));
        pulse_load();
        check_ref("R6", 14'h2A5B, 1, 0, 1, 0);
        send_word(ref_word(1'b0, 1'b1, 1'b0, 1'b1, 14'd3));
        pulse_load();
        check_ref("R6", 3, 0, 1, 0, 1);
    endtask

    task automatic t_le_held_r5();
        send_word(div_word(11'h0F0, 7'h0C));
        ser_load = 1'b1;
        wait_cyc(8);
        check_div("R5", 11'h0F0, 7'h0C);
        send_bit(1'b1);
        send_bit(1'b1);
        send_bit(1'b0);
        check_div("R5", 11'h0F0, 7'h0C);
        ser_load = 1'b0;
        wait_cyc(8);
        pulse_load();
        check_div("R5", 11'h0F0, 7'h0C);
        check_ref("R5", 3, 0, 1, 0, 1);
    endtask

    task automatic t_overlong_r10();
        send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b1);
        send_bit(1'b1);
        send_word(div_word(11'h6C1, 7'h3E));
        pulse_load();
        check_div("R10", 11'h6C1, 7'h3E);
    endtask

    task automatic t_coincide_r9();
        send_word(div_word(11'h123, 7'h11));
        ser_data = 1'b1;
        wait_cyc(4);
        ser_clk  = 1'b1;
        ser_load = 1'b1;
        wait_cyc(8);
        ser_clk  = 1'b0;
        ser_load = 1'b0;
        wait_cyc(8);
        check_div("R9", 11'h123, 7'h11);
        check_ref("R9", 3, 0, 1, 0, 1);
    endtask

    task automatic t_shift_order_r1();
        send_word(ref_word(1'b0, 1'b0, 1'b1, 1'b1, 14'h2001));
        pulse_load();
        check_ref("R1", 14'h2001, 0, 0, 1, 1);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(3);
        t_reset_r7();
        t_cleared_r8();
        t_ref_load_r2();
        t_div_load_r3();
        t_ref_limit_r6();
        t_le_held_r5();
        t_overlong_r10();
        t_coincide_r9();
        t_shift_order_r1();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge sys_clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule